// File: doc/BRIEF.md
# Converter Result Read Registers

This block holds the latest signed 13-bit sample from a converter core and lets a byte-wide bus read it as two registers. The upper byte carries the top eight result bits. The lower byte carries the remaining five result bits, two reserved zero bits and an overflow flag. A read of the upper byte copies the matching lower bits and overflow flag into a shadow byte. A following read of the lower byte returns that copy, even if the core delivered a newer sample between the two accesses. This keeps a split two-byte read coherent.

The converter core supplies the sample word, the overflow flag, a one-cycle `smp_done` strobe and a mode level (`conv_cont`, 1 = continuous, 0 = single-shot). It also pulses `conv_start` when a conversion begins. A small state machine tracks whether the held result may be trusted. It has three states:

- **ST_EMPTY**: the state after reset, with no result yet.
- **ST_SHOT_BUSY**: a single-shot conversion is running, so the held result is stale.
- **ST_VALID**: a completed result is held.

Its transitions are:

- **shot_begin**: ST_EMPTY or ST_VALID to ST_SHOT_BUSY, on `conv_start` while single-shot.
- **sample_land**: ST_EMPTY or ST_SHOT_BUSY to ST_VALID, on `smp_done`. It applies only when no single-shot start occurs in the same cycle, because a start takes priority.
- **hold**: every state stays put otherwise.

Top module: `adc_result_regs`

## Requirements
- R1: After reset, `result_valid` is 0 and `bus_rdata` is 0x00.
- R2: A read (`bus_rd`=1, `bus_wr`=0) of address 0xF72 places result bits [12:5] on `bus_rdata`[7:0] on the clock edge that samples the strobe. The value then holds until the next read.
- R3: A read of 0xF73 returns the shadow byte: bits [7:3] are result bits [4:0], bits [2:1] are 0, and bit 0 is the overflow flag. The shadow byte is the one captured by the most recent 0xF72 read.
- R4: A sample that arrives after a 0xF72 read and before the next 0xF73 read does not change the value of that 0xF73 read.
- R5: Every `smp_done` strobe replaces the held result and overflow flag. In continuous mode, the next 0xF72 read returns the newest sample.
- R6: `conv_start` with `conv_cont`=0 drives `result_valid` to 0 from the next cycle. `result_valid` stays 0 until the cycle after `smp_done`, when it returns to 1.
- R7: `conv_start` with `conv_cont`=1 leaves `result_valid` unchanged.
- R8: A cycle with `bus_wr`=1 is a write. It leaves `bus_rdata`, the held result and the shadow byte unchanged, at either address.
- R9: If `smp_done` and a 0xF72 read fall in the same cycle, the read returns the previous sample's upper byte. The shadow byte then takes the previous sample's lower bits and flag.
- R10: A read of any other address returns 0x00 and leaves the shadow byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | 13 | Signed sample from converter core |
| smp_ovf | input | 1 | Overflow flag for the sample |
| smp_done | input | 1 | One-cycle strobe: sample complete |
| conv_cont | input | 1 | Mode: 1 continuous, 0 single-shot |
| conv_start | input | 1 | One-cycle strobe: conversion begins |
| bus_addr | input | 12 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (writes are ignored) |
| bus_rdata | output | 8 | Registered read data |
| result_valid | output | 1 | Held result is trustworthy |

## Verification
Two of this block's functions can land on the same clock edge. The first is a sample landing from the core. The second is an upper-byte read, which captures the shadow byte. The bench provokes this by raising `smp_done` with a new sample in the very cycle that it strobes a read of 0xF72. It judges the outcome in two steps. The read must return the older sample's upper byte. The next 0xF73 read must then return the older sample's lower bits and flag, while a further 0xF72 read shows the new sample.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY     = 2'd0,
        ST_SHOT_BUSY = 2'd1,
        ST_VALID     = 2'd2
    } vstate_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2
    } sel_t;
endpackage

// File: rtl/adc_rr_decode.sv
module adc_rr_decode
    import adc_rr_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] PAGE_BASE = 12'hF00,
    parameter logic [11:0] HI_OFS    = 12'h072,
    parameter logic [11:0] LO_OFS    = 12'h073
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              rd_en,
    output sel_t              sel
);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(PAGE_BASE + HI_OFS);
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(PAGE_BASE + LO_OFS);

    always_comb begin
        rd_en = rd & ~wr;
        sel   = SEL_NONE;
        if (rd_en) begin
            if (addr == HI_ADDR)      sel = SEL_HI;
            else if (addr == LO_ADDR) sel = SEL_LO;
        end
    end
endmodule

// File: rtl/adc_rr_store.sv
module adc_rr_store #(
    parameter int RES_W  = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_done,
    input  logic [RES_W-1:0]  smp_data,
    input  logic              smp_ovf,
    input  logic              cap_shadow,
    output logic [DATA_W-1:0] hi_byte,
    output logic [DATA_W-1:0] lo_byte
);
    localparam int LO_W  = RES_W - DATA_W;
    localparam int RSV_W = DATA_W - LO_W - 1;

    logic [RES_W-1:0]  res_q;
    logic              ovf_q;
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] lo_live;

    always_comb begin
        lo_live = {res_q[LO_W-1:0], {RSV_W{1'b0}}, ovf_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= '0;
            ovf_q    <= 1'b0;
            shadow_q <= '0;
        end else begin
            if (smp_done) begin
                res_q <= smp_data;
                ovf_q <= smp_ovf;
            end
            if (cap_shadow) shadow_q <= lo_live;
        end
    end

    assign hi_byte = res_q[RES_W-1:LO_W];
    assign lo_byte = shadow_q;
endmodule

// File: rtl/adc_rr_valid_fsm.sv
module adc_rr_valid_fsm
    import adc_rr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start,
    input  logic conv_cont,
    input  logic smp_done,
    output logic valid
);
    vstate_t st_q, st_d;
    logic    shot_begin;

    assign shot_begin = conv_start & ~conv_cont;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: begin
                if (shot_begin)    st_d = ST_SHOT_BUSY;
                else if (smp_done) st_d = ST_VALID;
            end
            ST_SHOT_BUSY: begin
                if (!shot_begin && smp_done) st_d = ST_VALID;
            end
            ST_VALID: begin
                if (shot_begin) st_d = ST_SHOT_BUSY;
            end
            default: st_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        valid = (st_q == ST_VALID);
    end
endmodule

// File: rtl/adc_rr_rdmux.sv
module adc_rr_rdmux
    import adc_rr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  sel_t              sel,
    input  logic [DATA_W-1:0] hi_byte,
    input  logic [DATA_W-1:0] lo_byte,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (sel)
                SEL_HI:   rdata <= hi_byte;
                SEL_LO:   rdata <= lo_byte;
                default:  rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
    import adc_rr_pkg::*;
#(
    parameter int          RES_W     = 13,
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] PAGE_BASE = 12'hF00,
    parameter logic [11:0] HI_OFS    = 12'h072,
    parameter logic [11:0] LO_OFS    = 12'h073
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RES_W-1:0]  smp_data,
    input  logic              smp_ovf,
    input  logic              smp_done,
    input  logic              conv_cont,
    input  logic              conv_start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              result_valid
);
    logic              rd_en;
    sel_t              sel;
    logic [DATA_W-1:0] hi_byte;
    logic [DATA_W-1:0] lo_byte;
    logic              cap_shadow;

    adc_rr_decode #(
        .ADDR_W(ADDR_W), .PAGE_BASE(PAGE_BASE), .HI_OFS(HI_OFS), .LO_OFS(LO_OFS)
    ) decode_i (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .rd_en(rd_en), .sel(sel)
    );

    assign cap_shadow = (sel == SEL_HI);

    adc_rr_store #(.RES_W(RES_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n), .smp_done(smp_done), .smp_data(smp_data),
        .smp_ovf(smp_ovf), .cap_shadow(cap_shadow),
        .hi_byte(hi_byte), .lo_byte(lo_byte)
    );

    adc_rr_valid_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
        .conv_cont(conv_cont), .smp_done(smp_done), .valid(result_valid)
    );

    adc_rr_rdmux #(.DATA_W(DATA_W)) rdmux_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(sel),
        .hi_byte(hi_byte), .lo_byte(lo_byte), .rdata(bus_rdata)
    );
endmodule

// File: rtl/adc_result_regs_chk.sv
module adc_result_regs_chk #(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] PAGE_BASE = 12'hF00,
    parameter logic [11:0] HI_OFS    = 12'h072,
    parameter logic [11:0] LO_OFS    = 12'h073
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_done,
    input logic              conv_cont,
    input logic              conv_start,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              result_valid
);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(PAGE_BASE + HI_OFS);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(PAGE_BASE + LO_OFS);

    // R6
    shot_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !conv_cont) |=> !result_valid);

    // R6
    done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_done && !(conv_start && !conv_cont)) |=> result_valid);

    // R7
    cont_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && conv_cont && !smp_done) |=> $stable(result_valid));

    // R8
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> $stable(bus_rdata));

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == LO_A) |=> (bus_rdata[2:1] == 2'b00));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr != HI_A && bus_addr != LO_A) |=> (bus_rdata == '0));
endmodule

bind adc_result_regs adc_result_regs_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_BASE(PAGE_BASE),
    .HI_OFS(HI_OFS), .LO_OFS(LO_OFS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .smp_done(smp_done), .conv_cont(conv_cont),
    .conv_start(conv_start), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .result_valid(result_valid)
);

// File: tb/adc_result_regs_tb_top.sv
`timescale 1ns/1ps
module adc_result_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] smp_data = '0;
    logic        smp_ovf = 1'b0;
    logic        smp_done = 1'b0;
    logic        conv_cont = 1'b1;
    logic        conv_start = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        result_valid;

    always #2 clk = ~clk;

    adc_result_regs dut_i (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_ovf(smp_ovf),
        .smp_done(smp_done), .conv_cont(conv_cont), .conv_start(conv_start),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata), .result_valid(result_valid)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    logic [12:0] m_res = '0;
    logic        m_ovf = 1'b0;
    logic [7:0]  m_sh  = '0;
    logic        rd_seen = 1'b0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected read result pushed to scoreboard
    task automatic cyc(input string tag, input logic done, input logic [12:0] d,
                       input logic ovf, input logic rd, input logic wr,
                       input logic [11:0] a, input logic start);
        smp_done = done; smp_data = d; smp_ovf = ovf;
        bus_rd = rd; bus_wr = wr; bus_addr = a; conv_start = start;
        if (rd && !wr) begin
            if (a == 12'hF72) begin
                exp_q.push_back(m_res[12:5]);
                m_sh = {m_res[4:0], 2'b00, m_ovf};
            end else if (a == 12'hF73) exp_q.push_back(m_sh);
            else exp_q.push_back(8'h00);
            tag_q.push_back(tag);
        end
        if (done) begin m_res = d; m_ovf = ovf; end
        @(posedge clk);
        @(negedge clk);
        smp_done = 0; bus_rd = 0; bus_wr = 0; conv_start = 0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a);
        cyc(tag, 0, '0, 0, 1, 0, a, 0);
    endtask

    task automatic smp(input logic [12:0] d, input logic ovf);
        cyc("smp", 1, d, ovf, 0, 0, '0, 0);
    endtask

    // monitor
    always @(posedge clk) rd_seen <= bus_rd && !bus_wr && rst_n;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard underflow actual=%h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {7'b0, result_valid}, 8'h00);
        chk("R1 rdata after reset", bus_rdata, 8'h00);

        conv_cont = 1'b1;
        smp(13'h1A5B, 1'b1);
        chk("R6 valid after sample", {7'b0, result_valid}, 8'h01);
        rd("R2 high byte", 12'hF72);
        rd("R3 low byte", 12'hF73);

        rd("R2 high byte 2", 12'hF72);
        smp(13'h0C36, 1'b0);
        rd("R4 low after newer sample", 12'hF73);
        rd("R5 newest high", 12'hF72);
        rd("R3 low of newest", 12'hF73);

        smp(13'h0111, 1'b0);
        smp(13'h1000, 1'b1);
        rd("R5 after two samples", 12'hF72);

        cyc("R9 same-cycle high", 1, 13'h07FF, 1'b0, 1, 0, 12'hF72, 0);
        rd("R9 same-cycle low", 12'hF73);
        rd("R9 new high after", 12'hF72);

        @(negedge clk);
        hold = bus_rdata;
        cyc("wr", 0, '0, 0, 0, 1, 12'hF72, 0);
        cyc("wr", 0, '0, 0, 1, 1, 12'hF73, 0);
        chk("R8 rdata held over writes", bus_rdata, hold);
        rd("R8 low after writes", 12'hF73);
        rd("R8 high after writes", 12'hF72);

        rd("R10 unmapped F74", 12'hF74);
        rd("R10 wrong page 072", 12'h072);
        rd("R10 shadow kept", 12'hF73);

        cyc("start", 0, '0, 0, 0, 0, '0, 1);
        chk("R7 continuous start keeps valid", {7'b0, result_valid}, 8'h01);

        conv_cont = 1'b0;
        cyc("start", 0, '0, 0, 0, 0, '0, 1);
        chk("R6 single-shot start clears valid", {7'b0, result_valid}, 8'h00);
        repeat (3) @(negedge clk);
        chk("R6 stays invalid while busy", {7'b0, result_valid}, 8'h00);
        smp(13'h1FFF, 1'b1);
        chk("R6 valid after shot done", {7'b0, result_valid}, 8'h01);
        rd("R2 shot result high", 12'hF72);
        rd("R3 shot result low", 12'hF73);

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule